// File: doc/BRIEF.md
# Synchronous FIFO Flag Offset Programming Controller

This block owns the two offset registers that a synchronous FIFO uses to raise its near-empty and near-full flags. X is the near-empty offset and Y is the near-full offset. Three configuration pins are read once, when the active-low master reset is released. Their code picks one of three ways to fill the registers:

- a fixed preset value loaded into both registers;
- two writes on the 36-bit write port, in plain or parity-interspersed bit layout;
- a bit-serial stream on the configuration pins themselves.

The code stays in force until the next reset.

The block drives a ready signal that doubles as the FIFO's input-ready flag. It also drives a write strobe toward the storage array, which is high only for port writes that carry data rather than offsets. It raises a sticky error flag when an offset outside the legal range is loaded. The depth is a parameter. The offset width is log2 of the depth, so 11 bits for the default of 2048 entries.

Top module: `fifo_offset_prog`

## Requirements
- R1: The configuration code {cfg_sel2, cfg_sel1_sen_n, cfg_sel0_sd} is sampled on the first rising clock edge after rst_n goes high. That mode holds until the next reset, and later changes on those pins do not alter the mode or the offsets.
- R2: For preset codes, both X and Y load the same value: 3'b111 gives 64, 3'b110 gives 16, 3'b101 gives 8, 3'b011 gives 256 and 3'b001 gives 1024.
- R3: Code 3'b010 selects serial loading. Code 3'b100 selects parallel loading with the plain layout. Code 3'b000 selects parallel loading with the interspersed-parity layout.
- R4: In either parallel mode, the first qualified write loads Y and the second loads X. Neither of these asserts ram_we. Every later qualified write asserts ram_we in the same cycle.
- R5: In the plain layout the offset is wdata[N-1:0]. In the interspersed layout the offset is {wdata[N:9], wdata[7:0]}, so wdata[8] has no effect. In both layouts the highest-numbered bit is the MSB.
- R6: A write is qualified only when cs_n=0, wr_sel=1, wr_en=1, mbox_sel=0 and ready=1. Any other combination leaves the offsets unchanged and keeps ram_we low.
- R7: In serial mode, cfg_sel0_sd is shifted in on each rising edge while cfg_sel1_sen_n is 0. Edges with cfg_sel1_sen_n high are ignored. The 2N bits arrive as Y MSB-first followed by X MSB-first, and both registers update on the edge that takes the final bit.
- R8: In preset and parallel modes, ready rises on the sampling edge. In serial mode, ready stays low until all 2N bits are in, and rises on the edge after the final bit.
- R9: The legal offset range is 1 to DEPTH-4. Loading any offset outside that range sets cfg_err. cfg_err stays set until the next reset.
- R10: While rst_n is low, ready, cfg_err, ofs_x and ofs_y are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| cfg_sel2 | input | 1 | Configuration code bit 2 |
| cfg_sel1_sen_n | input | 1 | Code bit 1; after reset, active-low serial shift enable |
| cfg_sel0_sd | input | 1 | Code bit 0; after reset, serial offset data |
| cs_n | input | 1 | Write port chip select, active low |
| wr_sel | input | 1 | Port direction, 1 = write |
| wr_en | input | 1 | Write enable |
| mbox_sel | input | 1 | Mailbox select; a write with this high does not reach the FIFO |
| wdata | input | DATA_W | Write port data |
| ofs_x | output | N | Near-empty offset |
| ofs_y | output | N | Near-full offset |
| ready | output | 1 | Input ready; low until programming allows writes |
| ram_we | output | 1 | Qualified data write toward the storage array |
| cfg_err | output | 1 | Sticky out-of-range offset flag |

## Verification
The hardest case is the serial window. The bench must show that ready is still low right after the edge that takes the final bit, while the offsets have already changed, and that ready rises one edge later. It must also show that idle cycles with the enable high in the middle of the stream leave the shift count untouched.

The bench reaches this by streaming randomly chosen legal offsets MSB-first, with idle cycles scattered through the stream. It samples ready and both offsets on the negative edges around the final bit. The interspersed layout is driven with random values on wdata[8], so any use of that bit would show in the loaded offset.

// File: rtl/fop_pkg.sv
package fop_pkg;

    typedef enum logic [1:0] {
        M_PRESET    = 2'd0,
        M_SERIAL    = 2'd1,
        M_PAR_PLAIN = 2'd2,
        M_PAR_ILV   = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        ST_RST     = 3'd0,
        ST_SER     = 3'd1,
        ST_SER_FIN = 3'd2,
        ST_PAR_Y   = 3'd3,
        ST_PAR_X   = 3'd4,
        ST_RUN     = 3'd5
    } state_e;

endpackage

// File: rtl/fop_mode_decode.sv
module fop_mode_decode
    import fop_pkg::*;
#(
    parameter int OFS_W = 11
) (
    input  logic [2:0]       code,
    output mode_e            mode,
    output logic [OFS_W-1:0] preset
);
    always_comb begin
        mode   = M_PRESET;
        preset = '0;
        case (code)
            3'b111:  preset = OFS_W'(64);
            3'b110:  preset = OFS_W'(16);
            3'b101:  preset = OFS_W'(8);
            3'b011:  preset = OFS_W'(256);
            3'b001:  preset = OFS_W'(1024);
            3'b010:  mode   = M_SERIAL;
            3'b100:  mode   = M_PAR_PLAIN;
            default: mode   = M_PAR_ILV;
        endcase
    end
endmodule

// File: rtl/fop_word_extract.sv
module fop_word_extract #(
    parameter int OFS_W = 11
) (
    input  logic [OFS_W:0]   word,
    input  logic             ilv,
    output logic [OFS_W-1:0] ofs
);
    logic [OFS_W-1:0] plain_ofs;
    logic [OFS_W-1:0] ilv_ofs;

    assign plain_ofs = word[OFS_W-1:0];
    assign ilv_ofs   = {word[OFS_W:9], word[7:0]};
    assign ofs       = ilv ? ilv_ofs : plain_ofs;
endmodule

// File: rtl/fop_serial_shift.sv
module fop_serial_shift #(
    parameter int OFS_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic               sen_n,
    input  logic               sd,
    output logic               last_bit,
    output logic [2*OFS_W-1:0] word_nxt
);
    localparam int TOTAL = 2 * OFS_W;
    localparam int CNT_W = $clog2(TOTAL + 1);

    typedef struct packed {
        logic [TOTAL-1:0] sh;
        logic [CNT_W-1:0] cnt;
    } sreg_t;

    sreg_t s_q, s_d;
    logic  take;

    assign take     = active && !sen_n && (s_q.cnt < CNT_W'(TOTAL));
    assign word_nxt = {s_q.sh[TOTAL-2:0], sd};
    assign last_bit = take && (s_q.cnt == CNT_W'(TOTAL - 1));

    always_comb begin
        s_d = s_q;
        if (take) begin
            s_d.sh  = word_nxt;
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R7: the bit count never runs past the 2N offset bits
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(TOTAL));

endmodule

// File: rtl/fifo_offset_prog.sv
module fifo_offset_prog
    import fop_pkg::*;
#(
    parameter int DEPTH  = 2048,
    parameter int DATA_W = 36
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_sel2,
    input  logic                      cfg_sel1_sen_n,
    input  logic                      cfg_sel0_sd,
    input  logic                      cs_n,
    input  logic                      wr_sel,
    input  logic                      wr_en,
    input  logic                      mbox_sel,
    input  logic [DATA_W-1:0]         wdata,
    output logic [$clog2(DEPTH)-1:0]  ofs_x,
    output logic [$clog2(DEPTH)-1:0]  ofs_y,
    output logic                      ready,
    output logic                      ram_we,
    output logic                      cfg_err
);
    localparam int OFS_W = $clog2(DEPTH);
    localparam logic [OFS_W-1:0] MAX_OFS = OFS_W'(DEPTH - 4);

    typedef struct packed {
        state_e           state;
        mode_e            mode;
        logic             ready;
        logic             err;
        logic [OFS_W-1:0] x;
        logic [OFS_W-1:0] y;
    } regs_t;

    regs_t              st_q, st_d;
    mode_e              dec_mode;
    logic [OFS_W-1:0]   preset_val;
    logic [OFS_W-1:0]   ext_ofs;
    logic               ser_last;
    logic [2*OFS_W-1:0] ser_word;
    logic               wr_qual;
    logic               unused_hi;

    assign unused_hi = ^wdata[DATA_W-1:OFS_W+1];

    function automatic logic legal(input logic [OFS_W-1:0] v);
        return (v != '0) && (v <= MAX_OFS);
    endfunction

    fop_mode_decode #(.OFS_W(OFS_W)) i_decode (
        .code   ({cfg_sel2, cfg_sel1_sen_n, cfg_sel0_sd}),
        .mode   (dec_mode),
        .preset (preset_val)
    );

    fop_word_extract #(.OFS_W(OFS_W)) i_extract (
        .word (wdata[OFS_W:0]),
        .ilv  (st_q.mode == M_PAR_ILV),
        .ofs  (ext_ofs)
    );

    fop_serial_shift #(.OFS_W(OFS_W)) i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (st_q.state == ST_SER),
        .sen_n    (cfg_sel1_sen_n),
        .sd       (cfg_sel0_sd),
        .last_bit (ser_last),
        .word_nxt (ser_word)
    );

    assign wr_qual = !cs_n && wr_sel && wr_en && !mbox_sel && st_q.ready;

    always_comb begin
        st_d = st_q;
        case (st_q.state)
            ST_RST: begin
                st_d.mode = dec_mode;
                case (dec_mode)
                    M_PRESET: begin
                        st_d.x     = preset_val;
                        st_d.y     = preset_val;
                        st_d.err   = st_q.err || !legal(preset_val);
                        st_d.ready = 1'b1;
                        st_d.state = ST_RUN;
                    end
                    M_SERIAL: st_d.state = ST_SER;
                    default: begin
                        st_d.ready = 1'b1;
                        st_d.state = ST_PAR_Y;
                    end
                endcase
            end
            ST_SER: begin
                if (ser_last) begin
                    st_d.y     = ser_word[2*OFS_W-1:OFS_W];
                    st_d.x     = ser_word[OFS_W-1:0];
                    st_d.err   = st_q.err || !legal(ser_word[2*OFS_W-1:OFS_W])
                                          || !legal(ser_word[OFS_W-1:0]);
                    st_d.state = ST_SER_FIN;
                end
            end
            ST_SER_FIN: begin
                st_d.ready = 1'b1;
                st_d.state = ST_RUN;
            end
            ST_PAR_Y: begin
                if (wr_qual) begin
                    st_d.y     = ext_ofs;
                    st_d.err   = st_q.err || !legal(ext_ofs);
                    st_d.state = ST_PAR_X;
                end
            end
            ST_PAR_X: begin
                if (wr_qual) begin
                    st_d.x     = ext_ofs;
                    st_d.err   = st_q.err || !legal(ext_ofs);
                    st_d.state = ST_RUN;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_RST;
            st_q.mode  <= M_PRESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign ofs_x   = st_q.x;
    assign ofs_y   = st_q.y;
    assign ready   = st_q.ready;
    assign cfg_err = st_q.err;
    assign ram_we  = wr_qual && (st_q.state == ST_RUN);

    // R1: the latched mode never moves once sampled
    a_r1_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state != ST_RST) |=> $stable(st_q.mode));

    // R2: presets fill both offsets with one value
    a_r2_preset_same: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_RUN && st_q.mode == M_PRESET) |-> (ofs_x == ofs_y));

    // R4: first offset write lands in Y, then X is awaited
    a_r4_y_first: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_PAR_Y && wr_qual)
        |=> (st_q.state == ST_PAR_X && ofs_y == $past(ext_ofs)));

    // R8: ready follows the serial completion by one edge
    a_r8_serial_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_SER_FIN) |=> ready);

    // R9: error flag is sticky
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

endmodule

// File: tb/test_fifo_offset_prog.sv
module test_fifo_offset_prog;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 2048;
    localparam int N = $clog2(DEPTH);
    localparam int MAXV = DEPTH - 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fs2 = 1'b0, fs1 = 1'b0, fs0 = 1'b0;
    logic cs_n = 1'b1, wr_sel = 1'b0, wr_en = 1'b0, mbox = 1'b0;
    logic [35:0] wdata = '0;
    logic [N-1:0] ofs_x, ofs_y;
    logic ready, ram_we, cfg_err;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fifo_offset_prog #(.DEPTH(DEPTH), .DATA_W(36)) i_fifo_offset_prog (
        .clk(clk), .rst_n(rst_n), .cfg_sel2(fs2), .cfg_sel1_sen_n(fs1),
        .cfg_sel0_sd(fs0), .cs_n(cs_n), .wr_sel(wr_sel), .wr_en(wr_en),
        .mbox_sel(mbox), .wdata(wdata), .ofs_x(ofs_x), .ofs_y(ofs_y),
        .ready(ready), .ram_we(ram_we), .cfg_err(cfg_err));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_ofs(input logic [35:0] w, input bit ilv);
        logic [N-1:0] v;
        if (ilv) v = {w[N:9], w[7:0]};
        else     v = w[N-1:0];
        return int'(v);
    endfunction

    function automatic logic [35:0] make_word(input int v, input bit ilv);
        logic [35:0] w;
        logic [N-1:0] vv;
        w  = {$urandom, $urandom};
        vv = N'(v);
        if (ilv) begin
            w[7:0] = vv[7:0];
            w[N:9] = vv[N-1:8];
        end else begin
            w[N-1:0] = vv;
        end
        return w;
    endfunction

    task automatic idle_port();
        cs_n = 1'b1; wr_sel = 1'b0; wr_en = 1'b0; mbox = 1'b0;
    endtask

    // R10 checked during every reset
    task automatic reset_with(input logic [2:0] code);
        @(negedge clk);
        rst_n = 1'b0;
        {fs2, fs1, fs0} = code;
        idle_port();
        repeat (2) @(negedge clk);
        chk("R10 ready", ready, 0);
        chk("R10 err", cfg_err, 0);
        chk("R10 x", ofs_x, 0);
        chk("R10 y", ofs_y, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic port_write(input logic [35:0] w, input int exp_we, input string req);
        cs_n = 1'b0; wr_sel = 1'b1; wr_en = 1'b1; mbox = 1'b0; wdata = w;
        #1;
        chk(req, ram_we, exp_we);
        @(negedge clk);
        idle_port();
    endtask

    task automatic serial_send(input int y, input int x, input bit gaps);
        logic [2*N-1:0] stream;
        stream = {N'(y), N'(x)};
        for (int i = 2*N-1; i >= 0; i--) begin
            if (gaps && ($urandom_range(0, 2) == 0)) begin
                fs1 = 1'b1; fs0 = $urandom_range(0, 1);
                @(negedge clk);
            end
            fs1 = 1'b0; fs0 = stream[i];
            if (i == 0) chk("R8 ready low before final bit", ready, 0);
            @(negedge clk);
        end
        fs1 = 1'b1;
        chk("R8 ready low after final bit", ready, 0);
        chk("R7 serial y", ofs_y, y);
        chk("R7 serial x", ofs_x, x);
        @(negedge clk);
        chk("R8 ready after serial", ready, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [2:0] codes [5];
        int vals [5];
        void'($urandom(32'h5eed));
        codes = '{3'b111, 3'b110, 3'b101, 3'b011, 3'b001};
        vals  = '{64, 16, 8, 256, 1024};

        // R2 / R8 presets
        foreach (codes[k]) begin
            reset_with(codes[k]);
            chk("R8 preset ready", ready, 1);
            chk("R2 preset x", ofs_x, vals[k]);
            chk("R2 preset y", ofs_y, vals[k]);
            chk("R9 preset legal", cfg_err, 0);
            // R1: pin changes after sampling do nothing
            for (int c = 0; c < 4; c++) begin
                {fs2, fs1, fs0} = 3'($urandom_range(0, 7));
                @(negedge clk);
            end
            chk("R1 x held", ofs_x, vals[k]);
            port_write(36'h5, 1, "R1 R4 preset mode data write");
        end

        // R6 qualification in plain parallel mode (R3 code 100)
        reset_with(3'b100);
        chk("R8 parallel ready", ready, 1);
        for (int q = 0; q < 4; q++) begin
            cs_n = (q == 0); wr_sel = (q != 1); wr_en = (q != 2); mbox = (q == 3);
            wdata = 36'd77;
            #1;
            chk("R6 unqualified we", ram_we, 0);
            @(negedge clk);
            idle_port();
            chk("R6 y untouched", ofs_y, 0);
        end
        port_write(36'd100, 0, "R4 first write not data");
        chk("R4 y loaded", ofs_y, 100);
        port_write(36'd200, 0, "R4 second write not data");
        chk("R4 x loaded", ofs_x, 200);
        port_write(36'hF_FFFF_FFFF, 1, "R4 third write is data");
        chk("R4 offsets kept", ofs_y, 100);

        // R5 interspersed with bit 8 set (R3 code 000)
        reset_with(3'b000);
        begin
            logic [35:0] w;
            w = make_word(1000, 1'b1); w[8] = 1'b1;
            port_write(w, 0, "R4 ilv first");
            chk("R5 ilv y bit8 ignored", ofs_y, 1000);
            w = make_word(3, 1'b1); w[8] = 1'b1;
            port_write(w, 0, "R4 ilv second");
            chk("R5 ilv x", ofs_x, 3);
        end

        // R9 range edges
        reset_with(3'b100);
        port_write(36'd2044, 0, "R4 y max");
        chk("R9 max legal", cfg_err, 0);
        port_write(36'd0, 0, "R4 x zero");
        chk("R9 zero flagged", cfg_err, 1);
        port_write(36'd9, 1, "R4 data after error");
        chk("R9 sticky", cfg_err, 1);
        reset_with(3'b100);
        port_write(36'd2045, 0, "R4 y over");
        chk("R9 over flagged", cfg_err, 1);

        // R7 serial directed (R3 code 010)
        reset_with(3'b010);
        chk("R8 serial ready low", ready, 0);
        port_write(36'd5, 0, "R6 write blocked during serial");
        serial_send(1, MAXV, 1'b1);
        chk("R9 serial legal", cfg_err, 0);
        port_write(36'd5, 1, "R4 data after serial");
        reset_with(3'b010);
        serial_send(2047, 5, 1'b0);
        chk("R9 serial over flagged", cfg_err, 1);

        // random mix
        for (int it = 0; it < 24; it++) begin
            int m, yv, xv;
            m  = $urandom_range(0, 2);
            yv = $urandom_range(1, MAXV);
            xv = $urandom_range(1, MAXV);
            if (m == 2) begin
                reset_with(3'b010);
                serial_send(yv, xv, 1'b1);
            end else begin
                logic [35:0] w;
                bit ilv;
                ilv = (m == 1);
                reset_with(ilv ? 3'b000 : 3'b100);
                w = make_word(yv, ilv);
                port_write(w, 0, "R4 rand y write");
                chk("R5 rand y", ofs_y, exp_ofs(w, ilv));
                w = make_word(xv, ilv);
                port_write(w, 0, "R4 rand x write");
                chk("R5 rand x", ofs_x, exp_ofs(w, ilv));
            end
            port_write({$urandom, $urandom}, 1, "R4 rand data write");
            chk("R9 rand legal", cfg_err, 0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule